// File: doc/BRIEF.md
# Dual-Slot Accumulator Processor

This block is a small stored-program processor built around a single accumulator. Program and data share one word memory that is 40 bits wide, and every memory word carries two 20-bit instructions: a left slot and a right slot. After fetching a word, the processor runs the left slot at once and keeps the right slot in an instruction buffer. The following fetch then takes the right slot from the buffer without a memory read.

The processor drives a synchronous single-port memory. Address, write data and write enable go out in a cycle, and read data comes back on the next cycle. The internal registers are the program counter (PC), memory address register (MAR), memory buffer register (MBR), instruction register (IR), instruction buffer (IBR, with a valid flag) and accumulator (AC). Two debug outputs show AC and PC, and a halt output reports that execution has stopped. Supported operations:
- load and add from memory
- store of the accumulator to memory
- jump to the left or the right slot of a word
- conditional jump when the accumulator is non-negative
- halt

The sequencer uses six states:
- FETCH: takes the buffered right slot if one is held (transition FETCH→EXEC). Otherwise it places PC on the memory address (FETCH→FWAIT).
- FWAIT: splits the returned word into the slots (FWAIT→EXEC).
- EXEC: decodes IR. Load and add go to EXEC→OPER. Store and all jumps go to EXEC→FETCH. Halt and any unknown opcode go to EXEC→HALT.
- OPER: captures the operand into MBR (OPER→ACC).
- ACC: writes AC (ACC→FETCH).
- HALT: loops on itself (HALT→HALT).

Top module: `dual_slot_cpu`

## Requirements
- R1: While reset is low and in the first cycle after it, halted is 0, AC is 0 and PC is 0. Execution begins with the left slot of word 0.
- R2: Bit 39 is the most significant bit of a word. The left slot has its opcode in bits [39:32] and its address in [31:20]. The right slot has its opcode in [19:12] and its address in [11:0]. After a word is fetched from memory, its left slot runs first and its right slot runs next.
- R3: When the right slot is taken from the instruction buffer, the fetch costs one cycle and reads no memory word. PC does not change during that fetch.
- R4: Each word fetched from memory for instructions increments PC by exactly one. PC always names the next word to fetch.
- R5: Load (opcode 0x01) sets AC to M(X). Add (opcode 0x05) sets AC to AC + M(X) in 40-bit two's complement, wrapping on overflow.
- R6: Store (opcode 0x21) writes AC to M(X) in a single write cycle and leaves AC unchanged.
- R7: Jump-left (opcode 0x0D) sets PC to X, discards any buffered right slot, and continues with the left slot of word X.
- R8: Jump-right (opcode 0x0E) sets PC to X and fetches word X. It executes only the right slot of that word and then continues with word X+1.
- R9: Conditional jump (opcode 0x0F) behaves like jump-left when AC bit 39 is 0, which includes AC = 0. Otherwise execution continues in sequence, using the buffered right slot when one is held.
- R10: Halt (opcode 0x00) and every unlisted opcode stop execution. After that, halted stays 1, nothing is written to memory, and AC and PC stay frozen.
- R11: A fetch from the buffer takes 1 cycle and a fetch from memory takes 2 cycles. Load and add take 3 execute cycles, and every other opcode takes 1. halted rises after the halting instruction's execute cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 40 | Memory write data (AC) |
| mem_rdata | input | 40 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once execution has stopped |
| dbg_ac | output | 40 | Accumulator value |
| dbg_pc | output | 12 | Program counter value |

## Verification
The assertions check properties that must hold on every cycle:
- halt is sticky and produces no writes or jumps after it
- a store lasts exactly one cycle
- a buffered fetch leaves PC still and empties the buffer
- a memory fetch steps PC by one
- a jump-right arms a right-slot-only fetch

Only the directed scenarios can show the results that depend on whole programs:
- the slot order and field positions
- arithmetic wraparound
- which slot runs after each kind of jump
- the sign test of the conditional jump
- the exact halt cycle

For each scenario, a reference interpreter in the bench supplies the expected AC, PC, memory image and halt cycle.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    parameter int WORD_W = 40;
    parameter int OP_W   = 8;
    localparam int SLOT_W = WORD_W / 2;
    localparam int ADR_W  = SLOT_W - OP_W;

    localparam logic [OP_W-1:0] OP_HALT  = 8'h00;
    localparam logic [OP_W-1:0] OP_LOAD  = 8'h01;
    localparam logic [OP_W-1:0] OP_ADD   = 8'h05;
    localparam logic [OP_W-1:0] OP_JMPL  = 8'h0D;
    localparam logic [OP_W-1:0] OP_JMPR  = 8'h0E;
    localparam logic [OP_W-1:0] OP_JGEZ  = 8'h0F;
    localparam logic [OP_W-1:0] OP_STORE = 8'h21;

    typedef enum logic [2:0] {
        S_FETCH = 3'd0,
        S_FWAIT = 3'd1,
        S_EXEC  = 3'd2,
        S_OPER  = 3'd3,
        S_ACC   = 3'd4,
        S_HALT  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
    import dsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ibr_valid,
    input  logic [OP_W-1:0] ir,
    input  logic            ac_neg,
    output logic            ld_from_ibr,
    output logic            mem_rd_pc,
    output logic            ld_fetch_word,
    output logic            ld_operand,
    output logic            ld_ac,
    output logic            add_sel,
    output logic            do_store,
    output logic            take_jump,
    output logic            jump_right,
    output logic            halted
);
    seq_state_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FETCH;
        else        state <= state_nx;
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_FETCH: state_nx = ibr_valid ? S_EXEC : S_FWAIT;
            S_FWAIT: state_nx = S_EXEC;
            S_EXEC: begin
                unique case (ir)
                    OP_LOAD, OP_ADD:                     state_nx = S_OPER;
                    OP_STORE, OP_JMPL, OP_JMPR, OP_JGEZ: state_nx = S_FETCH;
                    default:                             state_nx = S_HALT;
                endcase
            end
            S_OPER:  state_nx = S_ACC;
            S_ACC:   state_nx = S_FETCH;
            S_HALT:  state_nx = S_HALT;
            default: state_nx = S_HALT;
        endcase
    end

    // control strobes
    always_comb begin
        ld_from_ibr   = 1'b0;
        mem_rd_pc     = 1'b0;
        ld_fetch_word = 1'b0;
        ld_operand    = 1'b0;
        ld_ac         = 1'b0;
        add_sel       = 1'b0;
        do_store      = 1'b0;
        take_jump     = 1'b0;
        jump_right    = 1'b0;
        halted        = 1'b0;
        unique case (state)
            S_FETCH: begin
                ld_from_ibr = ibr_valid;
                mem_rd_pc   = !ibr_valid;
            end
            S_FWAIT: ld_fetch_word = 1'b1;
            S_EXEC: begin
                do_store   = (ir == OP_STORE);
                take_jump  = (ir == OP_JMPL) || (ir == OP_JMPR) ||
                             ((ir == OP_JGEZ) && !ac_neg);
                jump_right = (ir == OP_JMPR);
            end
            S_OPER: ld_operand = 1'b1;
            S_ACC: begin
                ld_ac   = 1'b1;
                add_sel = (ir == OP_ADD);
            end
            S_HALT:  halted = 1'b1;
            default: halted = 1'b1;
        endcase
    end

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!do_store && !take_jump && !ld_ac));
    assert_store_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_store |=> !do_store);
endmodule

// File: rtl/dsc_datapath.sv
module dsc_datapath
    import dsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_from_ibr,
    input  logic              mem_rd_pc,
    input  logic              ld_fetch_word,
    input  logic              ld_operand,
    input  logic              ld_ac,
    input  logic              add_sel,
    input  logic              do_store,
    input  logic              take_jump,
    input  logic              jump_right,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              ibr_valid,
    output logic [OP_W-1:0]   ir,
    output logic [WORD_W-1:0] ac,
    output logic [ADR_W-1:0]  pc
);
    logic [ADR_W-1:0]  mar;
    logic [WORD_W-1:0] mbr;
    logic [SLOT_W-1:0] ibr;
    logic              right_only;

    assign mem_addr  = mem_rd_pc ? pc : mar;
    assign mem_wdata = ac;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc         <= '0;
            mar        <= '0;
            mbr        <= '0;
            ir         <= '0;
            ibr        <= '0;
            ibr_valid  <= 1'b0;
            right_only <= 1'b0;
            ac         <= '0;
        end else begin
            if (ld_from_ibr) begin
                ir        <= ibr[SLOT_W-1 -: OP_W];
                mar       <= ibr[ADR_W-1:0];
                ibr_valid <= 1'b0;
            end
            if (ld_fetch_word) begin
                mbr <= mem_rdata;
                pc  <= pc + 1'b1;
                if (right_only) begin
                    ir         <= mem_rdata[SLOT_W-1 -: OP_W];
                    mar        <= mem_rdata[ADR_W-1:0];
                    ibr_valid  <= 1'b0;
                    right_only <= 1'b0;
                end else begin
                    ir        <= mem_rdata[WORD_W-1 -: OP_W];
                    mar       <= mem_rdata[SLOT_W+ADR_W-1 -: ADR_W];
                    ibr       <= mem_rdata[SLOT_W-1:0];
                    ibr_valid <= 1'b1;
                end
            end
            if (ld_operand) mbr <= mem_rdata;
            if (ld_ac)      ac  <= add_sel ? (ac + mbr) : mbr;
            if (do_store)   mbr <= ac;
            if (take_jump) begin
                pc         <= mar;
                ibr_valid  <= 1'b0;
                right_only <= jump_right;
            end
        end
    end

    assert_buffered_fetch_pc_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_from_ibr |=> $stable(pc));
    assert_buffer_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_from_ibr |=> !ibr_valid);
    assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fetch_word |=> (pc == $past(pc) + 1'b1));
    assert_right_only_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_jump && jump_right) |=> (right_only && !ibr_valid));
endmodule

// File: rtl/dual_slot_cpu.sv
module dual_slot_cpu
    import dsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADR_W-1:0]  mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted,
    output logic [WORD_W-1:0] dbg_ac,
    output logic [ADR_W-1:0]  dbg_pc
);
    logic            ld_from_ibr, mem_rd_pc, ld_fetch_word, ld_operand;
    logic            ld_ac, add_sel, do_store, take_jump, jump_right;
    logic            ibr_valid;
    logic [OP_W-1:0] ir;

    dsc_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .ibr_valid(ibr_valid), .ir(ir),
        .ac_neg(dbg_ac[WORD_W-1]),
        .ld_from_ibr(ld_from_ibr), .mem_rd_pc(mem_rd_pc),
        .ld_fetch_word(ld_fetch_word), .ld_operand(ld_operand),
        .ld_ac(ld_ac), .add_sel(add_sel), .do_store(do_store),
        .take_jump(take_jump), .jump_right(jump_right), .halted(halted)
    );

    dsc_datapath u_dp (
        .clk(clk), .rst_n(rst_n), .ld_from_ibr(ld_from_ibr),
        .mem_rd_pc(mem_rd_pc), .ld_fetch_word(ld_fetch_word),
        .ld_operand(ld_operand), .ld_ac(ld_ac), .add_sel(add_sel),
        .do_store(do_store), .take_jump(take_jump), .jump_right(jump_right),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .ibr_valid(ibr_valid), .ir(ir), .ac(dbg_ac), .pc(dbg_pc)
    );

    assign mem_we = do_store;

    assert_no_write_when_halted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);
endmodule

// File: tb/sim_dual_slot_cpu.sv
`timescale 1ns/1ps
module sim_dual_slot_cpu;
    localparam int DEPTH = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [39:0] mem_wdata;
    logic [39:0] mem_rdata = '0;
    logic        halted;
    logic [39:0] dbg_ac;
    logic [11:0] dbg_pc;

    logic [39:0] mem     [0:DEPTH-1];
    logic [39:0] ref_mem [0:DEPTH-1];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dual_slot_cpu u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted),
        .dbg_ac(dbg_ac), .dbg_pc(dbg_pc)
    );

    always @(posedge clk) begin
        if (mem_we && mem_addr < DEPTH) mem[mem_addr] <= mem_wdata;
        mem_rdata <= (mem_addr < DEPTH) ? mem[mem_addr] : 40'd0;
    end

    function automatic logic [39:0] wd(input logic [7:0] opl, input logic [11:0] al,
                                       input logic [7:0] opr, input logic [11:0] ar);
        return {opl, al, opr, ar};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    endtask

    // Reference interpreter built from the requirements
    logic [39:0] m_ac;
    logic [11:0] m_pc;
    int          m_cyc;
    task automatic model_run();
        logic [19:0] ibr = '0;
        bit ibrv = 0, ronly = 0, stop = 0;
        logic [7:0] op;
        logic [11:0] x;
        logic [39:0] w;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = mem[i];
        m_ac = '0; m_pc = '0; m_cyc = 0;
        for (int k = 0; k < 2000 && !stop; k++) begin
            if (ibrv) begin
                op = ibr[19:12]; x = ibr[11:0]; ibrv = 0; m_cyc += 1;
            end else begin
                w = (m_pc < DEPTH) ? ref_mem[m_pc] : 40'd0;
                m_pc = m_pc + 1; m_cyc += 2;
                if (ronly) begin
                    op = w[19:12]; x = w[11:0]; ronly = 0;
                end else begin
                    op = w[39:32]; x = w[31:20]; ibr = w[19:0]; ibrv = 1;
                end
            end
            case (op)
                8'h01: begin m_ac = (x < DEPTH) ? ref_mem[x] : 40'd0; m_cyc += 3; end
                8'h05: begin m_ac = m_ac + ((x < DEPTH) ? ref_mem[x] : 40'd0); m_cyc += 3; end
                8'h21: begin if (x < DEPTH) ref_mem[x] = m_ac; m_cyc += 1; end
                8'h0D: begin m_pc = x; ibrv = 0; m_cyc += 1; end
                8'h0E: begin m_pc = x; ibrv = 0; ronly = 1; m_cyc += 1; end
                8'h0F: begin
                    if (!m_ac[39]) begin m_pc = x; ibrv = 0; end
                    m_cyc += 1;
                end
                default: begin m_cyc += 1; stop = 1; end
            endcase
        end
    endtask

    // Run the loaded program and compare with the interpreter
    task automatic run_and_check(input string req);
        int cyc = 0;
        int mism = 0;
        model_run();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        while (cyc < 5000) begin
            @(posedge clk); #1;
            cyc++;
            if (halted) break;
        end
        chk(req, "halted reached", {63'd0, halted}, 64'd1);
        chk({req, " R11"}, "halt cycle", 64'(cyc), 64'(m_cyc));
        chk(req, "AC", {24'd0, dbg_ac}, {24'd0, m_ac});
        chk({req, " R4"}, "PC", {52'd0, dbg_pc}, {52'd0, m_pc});
        for (int i = 0; i < DEPTH; i++) if (mem[i] !== ref_mem[i]) mism++;
        chk(req, "memory mismatches", 64'(mism), 64'd0);
    endtask

    task automatic t_reset();
        clear_mem();
        mem[0] = wd(8'h00, 12'd0, 8'h00, 12'd0);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "halted in reset", {63'd0, halted}, 64'd0);
        chk("R1", "AC in reset", {24'd0, dbg_ac}, 64'd0);
        chk("R1", "PC in reset", {52'd0, dbg_pc}, 64'd0);
        run_and_check("R1 R10");
    endtask

    task automatic t_load_add_store();
        clear_mem();
        mem[0] = wd(8'h01, 12'd100, 8'h05, 12'd101);
        mem[1] = wd(8'h21, 12'd102, 8'h05, 12'd102);
        mem[2] = wd(8'h21, 12'd103, 8'h00, 12'd0);
        mem[100] = 40'd5;
        mem[101] = -40'sd3;
        run_and_check("R2 R3 R5 R6");
        chk("R6", "M[103]", {24'd0, mem[103]}, 64'd4);
    endtask

    task automatic t_wrap();
        clear_mem();
        mem[0] = wd(8'h01, 12'd100, 8'h05, 12'd101);
        mem[1] = wd(8'h21, 12'd102, 8'h00, 12'd0);
        mem[100] = 40'h7F_FFFF_FFFF;
        mem[101] = 40'd1;
        run_and_check("R5");
        chk("R5", "wrapped sum", {24'd0, dbg_ac}, 64'h80_0000_0000);
    endtask

    task automatic t_jump_left();
        clear_mem();
        mem[0] = wd(8'h0D, 12'd2, 8'h21, 12'd112);
        mem[1] = wd(8'h21, 12'd113, 8'h00, 12'd0);
        mem[2] = wd(8'h01, 12'd100, 8'h05, 12'd100);
        mem[3] = wd(8'h21, 12'd111, 8'h00, 12'd0);
        mem[100] = 40'd21;
        mem[112] = 40'd77;
        run_and_check("R7");
        chk("R7", "skipped right slot left M[112]", {24'd0, mem[112]}, 64'd77);
        chk("R7", "M[111]", {24'd0, mem[111]}, 64'd42);
    endtask

    task automatic t_jump_right();
        clear_mem();
        mem[0] = wd(8'h01, 12'd100, 8'h0E, 12'd2);
        mem[2] = wd(8'h01, 12'd101, 8'h21, 12'd113);
        mem[3] = wd(8'h00, 12'd0, 8'h00, 12'd0);
        mem[100] = 40'd9;
        mem[101] = 40'd1234;
        run_and_check("R8");
        chk("R8", "left slot not run, M[113]", {24'd0, mem[113]}, 64'd9);
    endtask

    task automatic t_cond();
        clear_mem();
        mem[0] = wd(8'h0F, 12'd2, 8'h21, 12'd114);
        mem[2] = wd(8'h01, 12'd101, 8'h0F, 12'd5);
        mem[3] = wd(8'h21, 12'd115, 8'h01, 12'd100);
        mem[4] = wd(8'h0F, 12'd6, 8'h00, 12'd0);
        mem[6] = wd(8'h21, 12'd116, 8'h00, 12'd0);
        mem[100] = 40'd3;
        mem[101] = -40'sd8;
        mem[114] = 40'd9;
        run_and_check("R9");
        chk("R9", "taken on zero, M[114]", {24'd0, mem[114]}, 64'd9);
        chk("R9", "not taken on negative, M[115]", {24'd0, mem[115]}, {24'd0, -40'sd8});
        chk("R9", "taken on positive, M[116]", {24'd0, mem[116]}, 64'd3);
    endtask

    task automatic t_bad_opcode();
        logic [39:0] ac0;
        logic [11:0] pc0;
        clear_mem();
        mem[0] = wd(8'h01, 12'd100, 8'h77, 12'd0);
        mem[1] = wd(8'h21, 12'd117, 8'h00, 12'd0);
        mem[100] = 40'd55;
        run_and_check("R10");
        ac0 = dbg_ac; pc0 = dbg_pc;
        repeat (20) @(posedge clk);
        #1;
        chk("R10", "still halted", {63'd0, halted}, 64'd1);
        chk("R10", "AC frozen", {24'd0, dbg_ac}, {24'd0, ac0});
        chk("R10", "PC frozen", {52'd0, dbg_pc}, {52'd0, pc0});
        chk("R10", "M[117] untouched", {24'd0, mem[117]}, 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load_add_store();
        t_wrap();
        t_jump_left();
        t_jump_right();
        t_cond();
        t_bad_opcode();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule